// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces auto-refresh for a synchronous DRAM controller. A free-running prescaler divides the system clock. A three-bit select code picks one of seven tick rates, or stops counting altogether. An 8-bit up-counter advances on each selected tick and is compared against an 8-bit constant register. On a tick where the two are equal, the counter returns to zero and a compare-match flag is set. If refresh is enabled and auto mode is chosen, a refresh request is raised as well.

The controller answers with a one-cycle acknowledge at the start of its refresh cycle. The acknowledge drops both the flag and the request. Software programs the constant, the counter and the two mode bits first, then writes a nonzero select code. Writing the code does not disturb the counter, which resumes from the value it holds. Only the power-on reset clears the timer's state, so requests continue through any other reset or low-power state of the surrounding system.

Top module: `refresh_interval_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every register reads zero. This covers the counter, the constant, the control bits and the flag. `match_flag` and `rfsh_req` are 0.
- R2: The register addresses are: 0 control, 1 counter, 2 constant, 3 status. Control holds bits [2:0] select code, bit 3 refresh enable and bit 4 auto mode, and reads back as {3'b0, auto, enable, select}. Status reads {7'b0, flag}, and writes to it are ignored. `rd_data` shows the register at the `rd_addr` sampled on the previous edge.
- R3: Select code 0 stops the counter. Codes 1 to 7 give a tick once every 4, 16, 64, 256, 1024, 2048 and 4096 cycles respectively. The tick falls on the edge where the prescaler count, which starts at 0 after reset and increments every cycle, satisfies count mod N = N-1.
- R4: Writing a select code leaves the counter value unchanged, and counting continues from that value.
- R5: On a tick, a counter equal to the constant becomes 0 (a match). Any other counter value increments by one.
- R6: A match sets the flag. An acknowledge clears it. When a match and an acknowledge fall on the same edge, the flag is set.
- R7: A match raises `rfsh_req` only when both enable and auto mode are 1. The acknowledge clears the request, and a match wins over an acknowledge on the same edge. Without both bits, a match still clears the counter and sets the flag.
- R8: A software write to the counter on a tick edge loads the written value in place of the count or clear. A match on that edge still sets the flag.
- R9: An acknowledge while the flag and request are low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| rfsh_ack | input | 1 | Refresh cycle start acknowledge |
| rfsh_req | output | 1 | Refresh request |
| match_flag | output | 1 | Compare-match flag |

## Verification
Two pairs of events can fall on the same clock edge. A match can coincide with an acknowledge, and a software counter write can coincide with a tick. The bench predicts, from its own model, the edge on which a match or tick will occur. It then drives the acknowledge or the counter write onto exactly that edge. It expects the flag and request to stay set and the written value to survive, and it compares the flag, the request and a rotating register readback against the model on every cycle.

// File: rtl/rfit_pkg.sv
package rfit_pkg;
  localparam int SEL_W   = 3;
  localparam int ADDR_W  = 2;
  localparam int NCODES  = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CONST = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

  localparam int BIT_EN   = 3;
  localparam int BIT_AUTO = 4;

  typedef struct packed {
    logic             auto_m;
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // log2 of the divide ratio for each select code; 0 means stopped
  function automatic int div_log2(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rfit_prescaler.sv
module rfit_prescaler
  import rfit_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0]  pre_cnt;
  logic [NCODES-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + PRE_W'(1);
  end

  assign hit[0] = 1'b0;
  for (genvar g = 1; g < NCODES; g++) begin : g_div
    localparam int LG = div_log2(SEL_W'(g));
    if (LG > PRE_W) begin : g_too_narrow
      assign hit[g] = 1'b0;
    end else begin : g_tap
      assign hit[g] = &pre_cnt[LG-1:0];
    end
  end

  assign tick = hit[sel];
endmodule

// File: rtl/rfit_interval_counter.sv
module rfit_interval_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sel_zero,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cnst,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic equal;
  assign equal = (cnt == cnst);
  assign match = tick & equal;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= equal ? '0 : cnt + CNT_W'(1);
  end

  // R3: a stopped clock select freezes the counter unless software loads it
  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_zero && !load) |=> $stable(cnt));
  // R5: a match tick returns the counter to zero
  p_clear_on_match_r5: assert property (@(posedge clk) disable iff (rst)
    (match && !load) |=> (cnt == '0));
  // R8: a load always wins
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/rfit_request_ctrl.sv
module rfit_request_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic req_allowed,
  input  logic ack,
  output logic flag,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (match)    flag <= 1'b1;
      else if (ack) flag <= 1'b0;
      if (match && req_allowed) req <= 1'b1;
      else if (ack)             req <= 1'b0;
    end
  end

  // R6: a match sets the flag even against an acknowledge
  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);
  // R6: an acknowledge without a match clears the flag
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && !match) |=> !flag);
  // R7: a new request only when the mode bits allowed it
  p_req_gated_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(req_allowed));
  // R7: a request never stands without the flag
  p_req_implies_flag_r7: assert property (@(posedge clk) disable iff (rst)
    req |-> flag);
endmodule

// File: rtl/rfit_regs.sv
module rfit_regs
  import rfit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  cnst,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int CTL_W = $bits(ctl_t);

  logic [CNT_W-1:0] rd_mux;

  assign cnt_load = wr_en && (wr_addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      cnst <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)  ctl  <= ctl_t'(wr_data[CTL_W-1:0]);
      if (wr_addr == A_CONST) cnst <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_mux = CNT_W'(ctl);
      A_COUNT: rd_mux = cnt;
      A_CONST: rd_mux = cnst;
      default: rd_mux = CNT_W'(flag);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R2: the control word only changes through a write to its address
  p_ctl_write_only_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CTRL) |=> $stable(ctl));
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import rfit_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              rfsh_ack,
  output logic              rfsh_req,
  output logic              match_flag
);
  ctl_t             ctl;
  logic [CNT_W-1:0] cnst;
  logic [CNT_W-1:0] cnt;
  logic             cnt_load;
  logic             tick;
  logic             match;

  rfit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt), .flag(match_flag), .ctl(ctl), .cnst(cnst),
    .cnt_load(cnt_load), .rd_data(rd_data)
  );

  rfit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(ctl.sel), .tick(tick)
  );

  rfit_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .sel_zero(ctl.sel == '0),
    .load(cnt_load), .load_val(wr_data), .cnst(cnst), .cnt(cnt), .match(match)
  );

  rfit_request_ctrl u_req (
    .clk(clk), .rst(rst), .match(match), .req_allowed(ctl.en && ctl.auto_m),
    .ack(rfsh_ack), .flag(match_flag), .req(rfsh_req)
  );
endmodule

// File: tb/sim_refresh_interval_timer.sv
`timescale 1ns/1ps
module sim_refresh_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rfsh_ack = 1'b0;
  logic       rfsh_req;
  logic       match_flag;

  always #4 clk = ~clk;

  refresh_interval_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rfsh_ack(rfsh_ack),
    .rfsh_req(rfsh_req), .match_flag(match_flag)
  );

  int checks = 0, fails = 0, cycles = 0, ack_mode = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference model
  int         m_p = 0;
  logic [7:0] m_cnt = 0, m_cnst = 0, m_rd = 0;
  logic [2:0] m_sel = 0;
  logic       m_en = 0, m_auto = 0, m_flag = 0, m_req = 0;

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd1: return 4;    3'd2: return 16;   3'd3: return 64;
      3'd4: return 256;  3'd5: return 1024; 3'd6: return 2048;
      3'd7: return 4096; default: return 0;
    endcase
  endfunction

  function automatic bit will_tick();
    return (m_sel != 0) && ((m_p % ratio(m_sel)) == ratio(m_sel) - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_p = 0; m_cnt = 0; m_cnst = 0; m_rd = 0; m_sel = 0;
      m_en = 0; m_auto = 0; m_flag = 0; m_req = 0;
    end else begin
      bit tk, mt;
      tk = will_tick();
      mt = tk && (m_cnt == m_cnst);
      case (rd_addr)
        2'd0: m_rd = {3'b0, m_auto, m_en, m_sel};
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = m_cnst;
        default: m_rd = {7'b0, m_flag};
      endcase
      if (mt && m_en && m_auto) m_req = 1; else if (rfsh_ack) m_req = 0;
      if (mt) m_flag = 1; else if (rfsh_ack) m_flag = 0;
      if (wr_en && wr_addr == 2'd1) m_cnt = wr_data;
      else if (tk) m_cnt = mt ? 8'd0 : m_cnt + 8'd1;
      if (wr_en && wr_addr == 2'd0) begin
        m_sel = wr_data[2:0]; m_en = wr_data[3]; m_auto = wr_data[4];
      end
      if (wr_en && wr_addr == 2'd2) m_cnst = wr_data;
      m_p = (m_p + 1) % 4096;
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // compare on every cycle, away from the active edge; rotate the read address
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      chk("match_flag", match_flag, m_flag);
      chk("rfsh_req", rfsh_req, m_req);
      chk("rd_data", rd_data, m_rd);
    end
    rd_addr <= rd_addr + 2'd1;
    case (ack_mode)
      1: rfsh_ack <= m_req;
      2: rfsh_ack <= will_tick() && (m_cnt == m_cnst);
      3: rfsh_ack <= 1'b1;
      default: rfsh_ack <= 1'b0;
    endcase
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";                       // reset values, all addresses read back
    run(8);
    tag = "R5";                       // divide by 4, constant 6, auto-acked requests
    ack_mode = 1;
    wr(2'd2, 8'd6); wr(2'd1, 8'd0); wr(2'd0, 8'h19);
    run(200);
    tag = "R3";                       // select 0 holds the counter
    wr(2'd0, 8'h18);
    run(100);
    tag = "R4";                       // restart from the held value at divide 16
    wr(2'd0, 8'h1A);
    run(300);
    tag = "R7";                       // enable only, then auto only: no request
    wr(2'd0, 8'h09); run(100);
    wr(2'd0, 8'h11); run(100);
    tag = "R6";                       // acknowledge lands on the match edge
    ack_mode = 2;
    wr(2'd2, 8'd3); wr(2'd0, 8'h19);
    run(200);
    tag = "R9";                       // acknowledge with nothing pending
    ack_mode = 1; run(10);
    wr(2'd0, 8'h18); run(4);
    ack_mode = 3; run(30);
    wr(2'd0, 8'h19); run(100);
    ack_mode = 1;
    tag = "R8";                       // counter write on a tick edge
    wr(2'd2, 8'd200);
    for (int k = 0; k < 5; k++) begin
      while (!will_tick()) @(negedge clk);
      wr(2'd1, 8'h40 + 8'(k));
      run(7);
    end
    wr(2'd1, 8'd199); wr(2'd2, 8'd200);
    while (!(will_tick() && m_cnt == m_cnst)) @(negedge clk);
    wr(2'd1, 8'h22);                  // load on the match edge, flag still set
    run(20);
    tag = "R2";                       // status writes ignored, control readback
    wr(2'd3, 8'hFF); run(8);
    wr(2'd0, 8'h1F); run(8);
    tag = "R3";                       // every divide ratio
    for (int s = 2; s < 8; s++) begin
      wr(2'd0, 8'h18); wr(2'd2, 8'd2); wr(2'd1, 8'd0);
      wr(2'd0, 8'h18 | 8'(s));
      run(3 * ratio(3'(s)) + 50);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule